// File: doc/BRIEF.md
# Board Control Port Register Bank

This block sits on a byte-wide, ISA-style I/O port bus and provides the board-level control ports of a small computer platform. Software writes one special port to request a processor reset and to select the byte order. Other ports latch a disk-activity lamp, hold a 4-bit system control value and select the I/O address map mode. Further ports return fixed identification and equipment bytes.

The bus side has an address, write data, a read strobe and a write strobe. Read data is registered: it appears one clock after the read strobe and holds until the next read. On the system side, level outputs drive the processor reset request, the little-endian flag, the lamp, the system control nibble and the map-mode bit that feeds an external address translator. Writes to either of the two password-protect ports send a one-cycle toggle pulse to the non-volatile memory lock. A write to an address the bank does not decode raises a one-cycle error flag.

Top module: `board_ctrl_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cpu_reset_req`, `le_mode`, `disk_light`, `sys_ctrl`, `io_map_sel`, `lock_toggle`, `bad_wr` and `io_rdata` are all 0.
- R2: A write to port 0x0092 sets `cpu_reset_req` to data bit 0 and `le_mode` to data bit 1. Both are visible after the clock edge that samples the write and hold until the next write to that port.
- R3: A read of port 0x0092 returns 0x00.
- R4: Ports 0x0800, 0x0802 and 0x0803 read 0xEF, 0xAD and 0xE0. Writes to them change no output and raise no error.
- R5: A write to port 0x0808 sets `disk_light` to data bit 0.
- R6: A write to port 0x0810 pulses `lock_toggle[0]` and a write to 0x0812 pulses `lock_toggle[1]`, each high for exactly one cycle after the write edge. A read of 0x0810 returns 0x39.
- R7: A write to port 0x081C stores data bits 3:0 in `sys_ctrl`, and a read of 0x081C returns them zero-extended.
- R8: A write to port 0x0850 stores data bit 0 in `io_map_sel`, and a read of 0x0850 returns it in bit 0 with the other bits zero.
- R9: Port 0x080C reads 0x3C, 0x0818 reads 0x00 and 0x0823 reads 0x03. A write to 0x0814 changes nothing. Every other read address, including 0x0814, 0x0808 and 0x0812, returns 0xFF.
- R10: `io_rdata` updates only on a clock edge where `io_rd` is high, and it holds its value through cycles without a read.
- R11: A write to any address other than 0x0092, 0x0800, 0x0802, 0x0803, 0x0808, 0x0810, 0x0812, 0x0814, 0x081C and 0x0850 raises `bad_wr` for one cycle and changes no other output. Writes to the listed ports never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| cpu_reset_req | output | 1 | Processor reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| disk_light | output | 1 | Disk activity lamp state |
| sys_ctrl | output | 4 | System control value |
| io_map_sel | output | 1 | I/O map mode select for the address translator |
| lock_toggle | output | 2 | Lock toggle pulses; bit 0 is protect level 1, bit 1 is level 2 |
| bad_wr | output | 1 | One-cycle flag for a write to an undecoded port |

## Verification
The bench writes the special port with all four combinations of the two low data bits, so a design that swaps the reset and byte-order bits, or ties one to the other, reads back a wrong level. It writes all ones to the identification ports and then reads them again, which catches a constant stored in a writable flop. It also checks that those writes raise no error, which catches a decoder that flags read-only ports as unmapped. The lock pulses and the error flag are sampled in the cycle after the write and again one cycle later, so a level where a pulse belongs fails. Reads of 0x0812, 0x0814 and a random address expect 0xFF, and read data is checked again after idle cycles, so a decoder that falls through to the wrong byte or an unregistered read path shows up.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

   localparam int PORT_W   = 16;
   localparam int BYTE_W   = 8;
   localparam int NUM_LOCK = 2;

   localparam logic [PORT_W-1:0] P_SPECIAL = 16'h0092;
   localparam logic [PORT_W-1:0] P_ID_CPU  = 16'h0800;
   localparam logic [PORT_W-1:0] P_ID_FEAT = 16'h0802;
   localparam logic [PORT_W-1:0] P_ID_STAT = 16'h0803;
   localparam logic [PORT_W-1:0] P_LIGHT   = 16'h0808;
   localparam logic [PORT_W-1:0] P_EQUIP   = 16'h080C;
   localparam logic [PORT_W-1:0] P_LOCK1   = 16'h0810;
   localparam logic [PORT_W-1:0] P_LOCK2   = 16'h0812;
   localparam logic [PORT_W-1:0] P_CACHEINV = 16'h0814;
   localparam logic [PORT_W-1:0] P_KEYSW   = 16'h0818;
   localparam logic [PORT_W-1:0] P_SYSCTL  = 16'h081C;
   localparam logic [PORT_W-1:0] P_L2STAT  = 16'h0823;
   localparam logic [PORT_W-1:0] P_MAPTYPE = 16'h0850;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_SPECIAL,
      SEL_ID_CPU,
      SEL_ID_FEAT,
      SEL_ID_STAT,
      SEL_LIGHT,
      SEL_EQUIP,
      SEL_LOCK1,
      SEL_LOCK2,
      SEL_CACHEINV,
      SEL_KEYSW,
      SEL_SYSCTL,
      SEL_L2STAT,
      SEL_MAPTYPE
   } port_sel_e;

   function automatic port_sel_e lock_sel(input int idx);
      return (idx == 0) ? SEL_LOCK1 : SEL_LOCK2;
   endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
   import bcr_pkg::*;
#(
   parameter int ADDR_W = 16
)(
   input  logic [ADDR_W-1:0] addr,
   output port_sel_e         sel,
   output logic              wr_known
);

   initial begin
      if (ADDR_W < 12)
         $error("bcr_decode: ADDR_W must cover the 0x0800 port range");
   end

   always_comb begin
      sel = SEL_NONE;
      if      (addr == ADDR_W'(P_SPECIAL))  sel = SEL_SPECIAL;
      else if (addr == ADDR_W'(P_ID_CPU))   sel = SEL_ID_CPU;
      else if (addr == ADDR_W'(P_ID_FEAT))  sel = SEL_ID_FEAT;
      else if (addr == ADDR_W'(P_ID_STAT))  sel = SEL_ID_STAT;
      else if (addr == ADDR_W'(P_LIGHT))    sel = SEL_LIGHT;
      else if (addr == ADDR_W'(P_EQUIP))    sel = SEL_EQUIP;
      else if (addr == ADDR_W'(P_LOCK1))    sel = SEL_LOCK1;
      else if (addr == ADDR_W'(P_LOCK2))    sel = SEL_LOCK2;
      else if (addr == ADDR_W'(P_CACHEINV)) sel = SEL_CACHEINV;
      else if (addr == ADDR_W'(P_KEYSW))    sel = SEL_KEYSW;
      else if (addr == ADDR_W'(P_SYSCTL))   sel = SEL_SYSCTL;
      else if (addr == ADDR_W'(P_L2STAT))   sel = SEL_L2STAT;
      else if (addr == ADDR_W'(P_MAPTYPE))  sel = SEL_MAPTYPE;
   end

   // Ports that accept writes (including ignored read-only ones)
   always_comb begin
      unique case (sel)
         SEL_SPECIAL, SEL_ID_CPU, SEL_ID_FEAT, SEL_ID_STAT, SEL_LIGHT,
         SEL_LOCK1, SEL_LOCK2, SEL_CACHEINV, SEL_SYSCTL, SEL_MAPTYPE:
            wr_known = 1'b1;
         default:
            wr_known = 1'b0;
      endcase
   end

endmodule

// File: rtl/bcr_state.sv
module bcr_state
   import bcr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SYSCTL_W = 4,
   parameter int N_LOCK   = NUM_LOCK
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  port_sel_e           sel,
   input  logic                wr_known,
   input  logic [DATA_W-1:0]   wdata,
   output logic                reset_req,
   output logic                le_flag,
   output logic                light,
   output logic [SYSCTL_W-1:0] sysctl,
   output logic                map_sel,
   output logic [N_LOCK-1:0]   lock_pls,
   output logic                err_wr
);

   initial begin
      if (SYSCTL_W < 1 || SYSCTL_W > DATA_W)
         $error("bcr_state: SYSCTL_W must be 1..DATA_W");
      if (DATA_W < 2)
         $error("bcr_state: DATA_W must hold reset and endian bits");
      if (N_LOCK < 1 || N_LOCK > 2)
         $error("bcr_state: N_LOCK must be 1 or 2");
   end

   logic wr_special, wr_light, wr_sysctl, wr_map;
   assign wr_special = wr && (sel == SEL_SPECIAL);
   assign wr_light   = wr && (sel == SEL_LIGHT);
   assign wr_sysctl  = wr && (sel == SEL_SYSCTL);
   assign wr_map     = wr && (sel == SEL_MAPTYPE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_req <= 1'b0;
         le_flag   <= 1'b0;
      end else if (wr_special) begin
         reset_req <= wdata[0];
         le_flag   <= wdata[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        light <= 1'b0;
      else if (wr_light) light <= wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sysctl <= '0;
      else if (wr_sysctl) sysctl <= wdata[SYSCTL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      map_sel <= 1'b0;
      else if (wr_map) map_sel <= wdata[0];
   end

   for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lock_pls[g] <= 1'b0;
         else        lock_pls[g] <= wr && (sel == lock_sel(g));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_wr <= 1'b0;
      else        err_wr <= wr && !wr_known;
   end

   // R6: two lock pulses never coincide
   a_r6_locks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lock_pls));

   // R11: error flag and lock pulses never coincide
   a_r11_err_not_lock: assert property (@(posedge clk) disable iff (!rst_n)
      err_wr |-> (lock_pls == '0));

   // R2: reset request moves only after a special-port write
   a_r2_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_special) |-> $stable(reset_req) && $stable(le_flag));

   // R7: system control changes only after its write
   a_r7_sysctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_sysctl) |-> $stable(sysctl));

endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
   import bcr_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          SYSCTL_W  = 4,
   parameter logic [7:0]  ID_CPU    = 8'hEF,
   parameter logic [7:0]  ID_FEAT   = 8'hAD,
   parameter logic [7:0]  ID_STAT   = 8'hE0,
   parameter logic [7:0]  EQUIP     = 8'h3C,
   parameter logic [7:0]  EXT_FEAT  = 8'h39,
   parameter logic [7:0]  L2_STAT   = 8'h03
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  port_sel_e           sel,
   input  logic [SYSCTL_W-1:0] sysctl,
   input  logic                map_sel,
   output logic [DATA_W-1:0]   rdata
);

   initial begin
      if (DATA_W != BYTE_W)
         $error("bcr_rdmux: port bus is byte wide");
   end

   logic [DATA_W-1:0] sysctl_ext;
   if (SYSCTL_W == DATA_W) begin : g_sc_full
      assign sysctl_ext = sysctl;
   end else begin : g_sc_pad
      assign sysctl_ext = {{(DATA_W-SYSCTL_W){1'b0}}, sysctl};
   end

   logic [DATA_W-1:0] rd_next;
   always_comb begin
      unique case (sel)
         SEL_SPECIAL: rd_next = '0;
         SEL_ID_CPU:  rd_next = ID_CPU;
         SEL_ID_FEAT: rd_next = ID_FEAT;
         SEL_ID_STAT: rd_next = ID_STAT;
         SEL_EQUIP:   rd_next = EQUIP;
         SEL_LOCK1:   rd_next = EXT_FEAT;
         SEL_KEYSW:   rd_next = '0;
         SEL_SYSCTL:  rd_next = sysctl_ext;
         SEL_L2STAT:  rd_next = L2_STAT;
         SEL_MAPTYPE: rd_next = {{(DATA_W-1){1'b0}}, map_sel};
         default:     rd_next = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_next;
   end

   // R10: read data holds when no read was sampled
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd) |-> $stable(rdata));

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
   import bcr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] io_addr,
   input  logic [7:0]  io_wdata,
   input  logic        io_rd,
   input  logic        io_wr,
   output logic [7:0]  io_rdata,
   output logic        cpu_reset_req,
   output logic        le_mode,
   output logic        disk_light,
   output logic [3:0]  sys_ctrl,
   output logic        io_map_sel,
   output logic [1:0]  lock_toggle,
   output logic        bad_wr
);

   localparam int SYSCTL_W = 4;

   port_sel_e sel;
   logic      wr_known;

   bcr_decode #(.ADDR_W(PORT_W)) u_dec (
      .addr     (io_addr),
      .sel      (sel),
      .wr_known (wr_known)
   );

   bcr_state #(.DATA_W(BYTE_W), .SYSCTL_W(SYSCTL_W), .N_LOCK(NUM_LOCK)) u_st (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (io_wr),
      .sel       (sel),
      .wr_known  (wr_known),
      .wdata     (io_wdata),
      .reset_req (cpu_reset_req),
      .le_flag   (le_mode),
      .light     (disk_light),
      .sysctl    (sys_ctrl),
      .map_sel   (io_map_sel),
      .lock_pls  (lock_toggle),
      .err_wr    (bad_wr)
   );

   bcr_rdmux #(.DATA_W(BYTE_W), .SYSCTL_W(SYSCTL_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (io_rd),
      .sel     (sel),
      .sysctl  (sys_ctrl),
      .map_sel (io_map_sel),
      .rdata   (io_rdata)
   );

   // R2: reset request follows bit 0 of a special-port write
   a_r2_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(io_wr) && $past(io_addr) == P_SPECIAL) |->
         (cpu_reset_req == $past(io_wdata[0])) && (le_mode == $past(io_wdata[1])));

   // R6: a lock pulse follows a write to its port
   a_r6_lock1_cause: assert property (@(posedge clk) disable iff (!rst_n)
      lock_toggle[0] |-> $past(io_wr) && ($past(io_addr) == P_LOCK1));

   // R11: error flag follows a write
   a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |-> $past(io_wr));

   // R8: map mode changes only after a map-type write
   a_r8_map_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(io_wr) && $past(io_addr) == P_MAPTYPE) |-> $stable(io_map_sel));

endmodule

// File: tb/tb_board_ctrl_regs.sv
module tb_board_ctrl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_rdata;
   logic        cpu_reset_req, le_mode, disk_light, io_map_sel, bad_wr;
   logic [3:0]  sys_ctrl;
   logic [1:0]  lock_toggle;

   int n_chk = 0;
   int n_fail = 0;
   logic [1:0] snap_lock;
   logic       snap_err;
   logic [7:0] snap_rd;

   always #4 clk = ~clk;

   board_ctrl_regs dut (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk); #1;
      snap_lock = lock_toggle; snap_err = bad_wr;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd_port(input logic [15:0] a);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(posedge clk); #1;
      snap_rd = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R1 reset_req", cpu_reset_req, 0);
      chk("R1 le_mode", le_mode, 0);
      chk("R1 light", disk_light, 0);
      chk("R1 sys_ctrl", sys_ctrl, 0);
      chk("R1 map", io_map_sel, 0);
      chk("R1 lock", lock_toggle, 0);
      chk("R1 bad_wr", bad_wr, 0);
      chk("R1 rdata", io_rdata, 0);
   endtask

   task automatic t_special();
      wr_port(16'h0092, 8'h03);
      chk("R2 req after 03", cpu_reset_req, 1); chk("R2 le after 03", le_mode, 1);
      chk("R2 no err", snap_err, 0);
      wr_port(16'h0092, 8'hFE);
      chk("R2 req after FE", cpu_reset_req, 0); chk("R2 le after FE", le_mode, 1);
      wr_port(16'h0092, 8'h01);
      chk("R2 req after 01", cpu_reset_req, 1); chk("R2 le after 01", le_mode, 0);
      rd_port(16'h0092);
      chk("R3 read special", snap_rd, 8'h00);
      wr_port(16'h0092, 8'h00);
      chk("R2 req after 00", cpu_reset_req, 0); chk("R2 le after 00", le_mode, 0);
   endtask

   task automatic t_ids();
      logic [15:0] a [3] = '{16'h0800, 16'h0802, 16'h0803};
      logic [7:0]  v [3] = '{8'hEF, 8'hAD, 8'hE0};
      for (int i = 0; i < 3; i++) begin
         wr_port(a[i], 8'hFF);
         chk("R4 id write no err", snap_err, 0);
         rd_port(a[i]);
         chk("R4 id value", snap_rd, v[i]);
      end
      chk("R4 writes left sys_ctrl", sys_ctrl, 0);
      chk("R4 writes left map", io_map_sel, 0);
   endtask

   task automatic t_light();
      wr_port(16'h0808, 8'h01);
      chk("R5 light on", disk_light, 1);
      wr_port(16'h0808, 8'hFE);
      chk("R5 light off", disk_light, 0);
      rd_port(16'h0808);
      chk("R9 light port reads FF", snap_rd, 8'hFF);
   endtask

   task automatic t_locks();
      wr_port(16'h0810, 8'h00);
      chk("R6 lock1 pulse", snap_lock, 2'b01);
      @(posedge clk); #1;
      chk("R6 lock1 ends", lock_toggle, 2'b00);
      wr_port(16'h0812, 8'h5A);
      chk("R6 lock2 pulse", snap_lock, 2'b10);
      @(posedge clk); #1;
      chk("R6 lock2 ends", lock_toggle, 2'b00);
      rd_port(16'h0810);
      chk("R6 read 0810", snap_rd, 8'h39);
      rd_port(16'h0812);
      chk("R9 read 0812", snap_rd, 8'hFF);
   endtask

   task automatic t_sysctl();
      wr_port(16'h081C, 8'hA5);
      chk("R7 sys_ctrl low nibble", sys_ctrl, 4'h5);
      rd_port(16'h081C);
      chk("R7 read sys_ctrl", snap_rd, 8'h05);
      wr_port(16'h081C, 8'h3E);
      rd_port(16'h081C);
      chk("R7 read sys_ctrl 2", snap_rd, 8'h0E);
   endtask

   task automatic t_map();
      wr_port(16'h0850, 8'hFF);
      chk("R8 map set", io_map_sel, 1);
      rd_port(16'h0850);
      chk("R8 read map 1", snap_rd, 8'h01);
      wr_port(16'h0850, 8'hFE);
      chk("R8 map clear", io_map_sel, 0);
      rd_port(16'h0850);
      chk("R8 read map 0", snap_rd, 8'h00);
   endtask

   task automatic t_fixed();
      rd_port(16'h080C); chk("R9 equip", snap_rd, 8'h3C);
      rd_port(16'h0818); chk("R9 keyswitch", snap_rd, 8'h00);
      rd_port(16'h0823); chk("R9 l2 status", snap_rd, 8'h03);
      rd_port(16'h0123); chk("R9 unmapped read", snap_rd, 8'hFF);
      wr_port(16'h0814, 8'hFF);
      chk("R9 cacheinv no err", snap_err, 0);
      chk("R9 cacheinv left sys_ctrl", sys_ctrl, 4'hE);
      rd_port(16'h0814); chk("R9 cacheinv read", snap_rd, 8'hFF);
   endtask

   task automatic t_hold();
      rd_port(16'h0800);
      repeat (3) @(posedge clk);
      #1;
      chk("R10 rdata held", io_rdata, 8'hEF);
      @(negedge clk);
      io_addr = 16'h080C;
      @(posedge clk); #1;
      chk("R10 no update without rd", io_rdata, 8'hEF);
   endtask

   task automatic t_unmapped();
      wr_port(16'h0804, 8'hFF);
      chk("R11 err raised", snap_err, 1);
      chk("R11 no lock", snap_lock, 0);
      @(posedge clk); #1;
      chk("R11 err one cycle", bad_wr, 0);
      chk("R11 sys_ctrl untouched", sys_ctrl, 4'hE);
      chk("R11 map untouched", io_map_sel, 0);
      wr_port(16'h0000, 8'h01);
      chk("R11 err addr 0", snap_err, 1);
      chk("R11 req untouched", cpu_reset_req, 0);
   endtask

   task automatic t_reset_again();
      wr_port(16'h0092, 8'h03);
      wr_port(16'h0808, 8'h01);
      wr_port(16'h0850, 8'h01);
      rd_port(16'h0800);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset_state();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset_state();
      t_special();
      t_ids();
      t_light();
      t_locks();
      t_sysctl();
      t_map();
      t_fixed();
      t_hold();
      t_unmapped();
      t_reset_again();
      summary();
      $finish;
   end

endmodule